// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Port with Transmit and Receive FIFOs

This block is a full-duplex synchronous serial port. Software writes bytes one at a time into a data register, which feeds a transmit FIFO of up to sixteen entries. A shift engine takes the oldest byte from the FIFO into a shift register and drives it out on a serial data line. The serial clock it generates has a programmable rate and a selectable idle level. For every bit it sends, the engine also samples the serial input. Each completed incoming byte goes into a receive FIFO, which software empties by reading the same data register.

Two separate conditions are reported: the transmit FIFO has drained, and the shifter has gone idle. Each has a status flag and its own interrupt line, and each line has its own enable. A whole batch goes out without gaps between bytes. Bit order (most or least significant first) is sampled when each byte is loaded, and the same order is used to assemble the received byte.

Register map, on a 2-bit address: 0 is data (a write pushes to the transmit FIFO, a read pops the receive FIFO); 1 is control; 2 is divisor; 3 is status.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, status reads 0x03 (buffer-empty bit 0 and shifter-empty bit 1 set, overflow bit 2 clear). Control and divisor read 0. The serial clock sits at its idle level, serial out is low, and both interrupt lines are low.
- R2: The transmit FIFO accepts a data write only while it holds fewer than 16 bytes. A write to a full FIFO is dropped and sets the sticky overflow flag (status bit 2). Writing 1 to status bit 2 clears that flag.
- R3: While the shifter is idle and the FIFO holds data, the oldest byte is loaded into the shifter on the next clock and the shifter-empty flag clears. If that byte was the last one in the FIFO and no write arrives in the same cycle, the buffer-empty flag sets.
- R4: Control bit 0 selects bit order. When it is 0, bit 7 goes out first and bit 0 last. When it is 1, bit 0 goes out first. The bit is sampled at each byte load.
- R5: When a byte's last bit ends and the FIFO still holds data, the next byte is loaded in the same cycle, with no idle clock between bytes. When the FIFO is empty at that point, the shifter stops and the shifter-empty flag sets.
- R6: An accepted data write clears both the buffer-empty flag and the shifter-empty flag.
- R7: Serial input is sampled once per bit and assembled in the byte's bit order. At the end of each byte the result is pushed to the receive FIFO (16 deep; pushes to a full FIFO are dropped). Reading the data register returns and removes the oldest received byte. When the receive FIFO is empty, the read returns 0.
- R8: With divisor N (register 2), each half of the serial clock lasts N+1 system clocks, so the period is 2·(N+1). Control bit 1 sets the idle level. The input is sampled on the edge that leaves the idle level, and serial out changes only on the edge that returns to it.
- R9: The buffer interrupt equals buffer-empty AND control bit 2. The shifter interrupt equals shifter-empty AND control bit 3. Both are level outputs.
- R10: Control reads back {4'b0, bit3, bit2, bit1, bit0} as written, and divisor reads back its 8-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | Register select |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (pops receive FIFO at address 0) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq_buf | output | 1 | Transmit FIFO drained interrupt |
| irq_shf | output | 1 | Shifter idle interrupt |

## Verification
A single byte with the FIFO otherwise empty shows the load, the last-byte flag and the stop to idle as separate events. A burst of several bytes shows whether reloading happens in the same cycle, because any idle gap would shift every later serial clock edge compared with the reference model. Switching to least-significant-first order, inverted idle polarity and a different divisor separates mistakes in shift direction, polarity and half-period length. Random serial input shows whether the received bytes are assembled in the matching order. Overfilling the transmit FIFO and then over-reading the receive FIFO covers the dropped write, the sticky flag, and the zero returned by an empty read.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_CTRL = 2'd1,
    A_DIV  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic shf_ie;
    logic buf_ie;
    logic clk_pol;
    logic lsb_first;
  } ctrl_t;

  localparam int unsigned STAT_OVF_BIT = 2;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_n  = push_ok ? bump(wp_q) : wp_q;
    rp_n  = pop_ok  ? bump(rp_q) : rp_q;
    cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;

  // R7: count never exceeds the depth
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/ssp_sclk_gen.sv
module ssp_sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             lead,
  output logic             trail,
  output logic             phase
);
  logic [DIV_W-1:0] hcnt_q, hcnt_n;
  logic             ph_q, ph_n, tick;

  assign tick  = run && (hcnt_q == div);
  assign lead  = tick && !ph_q;
  assign trail = tick && ph_q;
  assign phase = ph_q;

  always_comb begin
    hcnt_n = hcnt_q;
    ph_n   = ph_q;
    if (!run) begin
      hcnt_n = '0;
      ph_n   = 1'b0;
    end else if (tick) begin
      hcnt_n = '0;
      ph_n   = !ph_q;
    end else begin
      hcnt_n = hcnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      ph_q   <= 1'b0;
    end else begin
      hcnt_q <= hcnt_n;
      ph_q   <= ph_n;
    end
  end

  // R8: idle generator stays in the idle half
  p_idle_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !ph_q);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned W = 8,
  localparam int unsigned BCW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lsb_sel,
  input  logic         tx_avail,
  input  logic [W-1:0] tx_head,
  input  logic         sdi,
  input  logic         lead,
  input  logic         trail,
  output logic         busy,
  output logic         tx_pop,
  output logic         rx_push,
  output logic [W-1:0] rx_byte,
  output logic         idle_done,
  output logic         sdo
);
  logic           busy_q, busy_n, lsb_q, lsb_n, load;
  logic [BCW-1:0] bitn_q, bitn_n;
  logic [W-1:0]   txsh_q, txsh_n, rxsh_q, rxsh_n;

  always_comb begin
    busy_n    = busy_q;
    lsb_n     = lsb_q;
    bitn_n    = bitn_q;
    txsh_n    = txsh_q;
    rxsh_n    = rxsh_q;
    load      = 1'b0;
    rx_push   = 1'b0;
    idle_done = 1'b0;
    if (!busy_q) begin
      load = tx_avail;
    end else begin
      if (lead) begin
        rxsh_n = lsb_q ? {sdi, rxsh_q[W-1:1]} : {rxsh_q[W-2:0], sdi};
      end
      if (trail) begin
        if (bitn_q == BCW'(W - 1)) begin
          rx_push = 1'b1;
          if (tx_avail) begin
            load = 1'b1;
          end else begin
            busy_n    = 1'b0;
            idle_done = 1'b1;
          end
        end else begin
          bitn_n = bitn_q + BCW'(1);
          txsh_n = lsb_q ? (txsh_q >> 1) : (txsh_q << 1);
        end
      end
    end
    if (load) begin
      busy_n = 1'b1;
      bitn_n = '0;
      txsh_n = tx_head;
      lsb_n  = lsb_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lsb_q  <= 1'b0;
      bitn_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      busy_q <= busy_n;
      lsb_q  <= lsb_n;
      bitn_q <= bitn_n;
      txsh_q <= txsh_n;
      rxsh_q <= rxsh_n;
    end
  end

  assign busy    = busy_q;
  assign tx_pop  = load;
  assign rx_byte = rxsh_q;
  assign sdo     = busy_q && (lsb_q ? txsh_q[0] : txsh_q[W-1]);

  // R8: serial out moves only on a trailing edge or a fresh load from idle
  p_sdo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && !$past(trail) |-> $stable(sdo));

  // R5: byte end with data waiting keeps the engine running
  p_gapless_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && tx_avail |=> busy_q);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV_W = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       sclk,
  output logic       sdo,
  input  logic       sdi,
  output logic       irq_buf,
  output logic       irq_shf
);
  import ssp_pkg::*;

  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  ctrl_t             ctrl_q, ctrl_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic              bufe_q, bufe_n, shfe_q, shfe_n, ovf_q, ovf_n;
  logic [CW-1:0]     tx_count, rx_count;
  logic [BYTE_W-1:0] tx_head, rx_head, rx_byte;
  logic              data_wr, tx_full, tx_accept, rx_pop;
  logic              tx_pop, rx_push, idle_done, busy;
  logic              lead, trail, phase;

  assign data_wr   = cpu_wr && (cpu_addr == A_DATA);
  assign tx_full   = (tx_count == CW'(DEPTH));
  assign tx_accept = data_wr && !tx_full;
  assign rx_pop    = cpu_rd && (cpu_addr == A_DATA);

  ssp_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .push(tx_accept), .wdata(cpu_wdata),
    .pop(tx_pop), .rdata(tx_head), .count(tx_count));

  ssp_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .count(rx_count));

  ssp_sclk_gen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_i), .run(busy), .div(div_q),
    .lead(lead), .trail(trail), .phase(phase));

  ssp_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_i), .lsb_sel(ctrl_q.lsb_first),
    .tx_avail(tx_count != '0), .tx_head(tx_head), .sdi(sdi),
    .lead(lead), .trail(trail), .busy(busy), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .idle_done(idle_done), .sdo(sdo));

  always_comb begin
    ctrl_n = ctrl_q;
    div_n  = div_q;
    bufe_n = bufe_q;
    shfe_n = shfe_q;
    ovf_n  = ovf_q;
    if (cpu_wr && cpu_addr == A_CTRL) ctrl_n = ctrl_t'(cpu_wdata[3:0]);
    if (cpu_wr && cpu_addr == A_DIV)  div_n  = cpu_wdata[DIV_W-1:0];
    if (cpu_wr && cpu_addr == A_STAT && cpu_wdata[STAT_OVF_BIT]) ovf_n = 1'b0;
    if (data_wr && tx_full) ovf_n = 1'b1;
    if (tx_pop && tx_count == CW'(1)) bufe_n = 1'b1;
    if (idle_done) shfe_n = 1'b1;
    if (tx_pop)    shfe_n = 1'b0;
    if (tx_accept) begin
      bufe_n = 1'b0;
      shfe_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0;
      div_q  <= '0;
      bufe_q <= 1'b1;
      shfe_q <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      div_q  <= div_n;
      bufe_q <= bufe_n;
      shfe_q <= shfe_n;
      ovf_q  <= ovf_n;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(cpu_addr))
      A_DATA:  cpu_rdata = (rx_count != '0) ? rx_head : '0;
      A_CTRL:  cpu_rdata = {4'b0, ctrl_q};
      A_DIV:   cpu_rdata = 8'(div_q);
      default: cpu_rdata = {5'b0, ovf_q, shfe_q, bufe_q};
    endcase
  end

  assign sclk    = ctrl_q.clk_pol ^ (busy && phase);
  assign irq_buf = bufe_q && ctrl_q.buf_ie;
  assign irq_shf = shfe_q && ctrl_q.shf_ie;

  // R2: a write to a full FIFO leaves it unchanged and flags overflow
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_i)
    data_wr && tx_full && !tx_pop |=> tx_count == $past(tx_count) && ovf_q);

  // R3: buffer-empty only rises when the FIFO has drained
  p_bufe_drained_r3: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(bufe_q) |-> tx_count == '0);

  // R5: shifter-empty only rises with the engine stopped
  p_shfe_idle_r5: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(shfe_q) |-> !busy);

  // R6: an accepted write clears both flags
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_i)
    tx_accept |=> !bufe_q && !shfe_q);
endmodule

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       sclk, sdo, irq_buf, irq_shf;
  logic       sdi = 1'b0;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .irq_buf(irq_buf), .irq_shf(irq_shf));

  // behavioural reference
  logic [7:0] q[$];
  logic [7:0] rxq[$];
  bit m_busy, m_ph, m_lsb, m_bufE, m_shfE, m_ovf;
  bit c_lsb, c_pol, c_ben, c_sen;
  int m_hc, m_bn;
  logic [7:0] m_cur, m_rx, m_div;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); rxq.delete();
      m_busy = 0; m_ph = 0; m_lsb = 0; m_bufE = 1; m_shfE = 1; m_ovf = 0;
      c_lsb = 0; c_pol = 0; c_ben = 0; c_sen = 0;
      m_hc = 0; m_bn = 0; m_cur = 0; m_rx = 0; m_div = 0;
    end else begin
      int c0, r0;
      bit wd, acc, ld;
      c0 = q.size(); r0 = rxq.size();
      wd = cpu_wr && cpu_addr == 2'd0;
      acc = wd && c0 < 16;
      ld = 0;
      if (cpu_rd && cpu_addr == 2'd0 && r0 > 0) void'(rxq.pop_front());
      if (!m_busy) begin
        if (c0 > 0) ld = 1;
      end else if (m_hc == int'(m_div)) begin
        m_hc = 0;
        if (!m_ph) begin
          m_ph = 1;
          m_rx = m_lsb ? {sdi, m_rx[7:1]} : {m_rx[6:0], sdi};
        end else begin
          m_ph = 0;
          if (m_bn == 7) begin
            if (r0 < 16) rxq.push_back(m_rx);
            if (c0 > 0) ld = 1;
            else begin m_busy = 0; m_shfE = 1; end
          end else begin
            m_bn++;
            m_cur = m_lsb ? (m_cur >> 1) : (m_cur << 1);
          end
        end
      end else m_hc++;
      if (ld) begin
        m_cur = q.pop_front(); m_lsb = c_lsb; m_busy = 1;
        m_hc = 0; m_ph = 0; m_bn = 0; m_shfE = 0;
        if (c0 == 1 && !acc) m_bufE = 1;
      end
      if (acc) begin q.push_back(cpu_wdata); m_bufE = 0; m_shfE = 0; end
      else if (wd) m_ovf = 1;
      if (cpu_wr && cpu_addr == 2'd1) {c_sen, c_ben, c_pol, c_lsb} = cpu_wdata[3:0];
      if (cpu_wr && cpu_addr == 2'd2) m_div = cpu_wdata;
      if (cpu_wr && cpu_addr == 2'd3 && cpu_wdata[2]) m_ovf = 0;
    end
  end

  function automatic logic [7:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0: return (rxq.size() > 0) ? rxq[0] : 8'd0;
      2'd1: return {4'b0, c_sen, c_ben, c_pol, c_lsb};
      2'd2: return m_div;
      default: return {5'b0, m_ovf, m_shfE, m_bufE};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock port comparison
  always @(negedge clk) begin
    sdi <= 1'($urandom_range(0, 1));
    if (rst_n && !done) begin
      logic e_sclk, e_sdo;
      e_sclk = c_pol ^ (m_busy && m_ph);
      e_sdo = m_busy && (m_lsb ? m_cur[0] : m_cur[7]);
      chk(sclk === e_sclk, "R8 sclk", int'(sclk), int'(e_sclk));
      chk(sdo === e_sdo, "R4 sdo", int'(sdo), int'(e_sdo));
      chk(irq_buf === (m_bufE && c_ben), "R3 irq_buf", int'(irq_buf), int'(m_bufE && c_ben));
      chk(irq_shf === (m_shfE && c_sen), "R5 irq_shf", int'(irq_shf), int'(m_shfE && c_sen));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    #1 e = model_rd(a);
    chk(cpu_rdata === e, tag, int'(cpu_rdata), int'(e));
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && (m_busy || q.size() > 0); i++) @(negedge clk);
  endtask

  task automatic drain_rx(input int n);
    for (int i = 0; i < n; i++) rd(2'd0, "R7 rx data");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_tests++; n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    rd(2'd3, "R1 status");
    chk(cpu_rdata == 8'h03, "R1 status value", int'(cpu_rdata), 3);
    rd(2'd1, "R1 ctrl");
    rd(2'd2, "R1 div");
    chk(sclk == 0 && sdo == 0 && !irq_buf && !irq_shf, "R1 outputs", int'({sclk, sdo, irq_buf, irq_shf}), 0);

    // R10 / R9: register readback and masked interrupt
    wr(2'd1, 8'h03); rd(2'd1, "R10 ctrl readback");
    chk(irq_buf == 0, "R9 masked irq_buf", int'(irq_buf), 0);
    wr(2'd1, 8'h0C); rd(2'd1, "R10 ctrl readback");
    @(negedge clk);
    chk(irq_buf == 1 && irq_shf == 1, "R9 enabled irqs", int'({irq_buf, irq_shf}), 3);
    wr(2'd2, 8'd1); rd(2'd2, "R10 div readback");

    // single byte, MSB first
    wr(2'd0, 8'hA5);
    rd(2'd3, "R6 status after write");
    wait_idle(); repeat (2) @(negedge clk);
    rd(2'd3, "R5 status after idle");
    chk(cpu_rdata == 8'h03, "R5 both empty", int'(cpu_rdata), 3);
    drain_rx(2);

    // burst, MSB first, back to back
    for (int i = 0; i < 4; i++) wr(2'd0, 8'(8'h31 * (i + 1)));
    rd(2'd3, "R3 status mid burst");
    wait_idle(); repeat (2) @(negedge clk);
    drain_rx(5);

    // LSB first, inverted idle level, divisor 3
    wr(2'd1, 8'h0F); wr(2'd2, 8'd3);
    chk(sclk == 1, "R8 idle level", int'(sclk), 1);
    wr(2'd0, 8'h1E); wr(2'd0, 8'hC3);
    wait_idle(); repeat (2) @(negedge clk);
    drain_rx(3);

    // R8 period with divisor 2, polarity 0
    wr(2'd1, 8'h0C); wr(2'd2, 8'd2);
    wr(2'd0, 8'h5A);
    begin
      int t0, cyc;
      bit prev, seen;
      prev = sclk; seen = 0; t0 = 0; cyc = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk); cyc++;
        if (sclk && !prev) begin
          if (seen) begin chk(cyc - t0 == 6, "R8 period", cyc - t0, 6); break; end
          seen = 1; t0 = cyc;
        end
        prev = sclk;
      end
    end
    wait_idle(); repeat (2) @(negedge clk);
    drain_rx(1);

    // R2 overflow, R7 receive FIFO full and empty reads
    wr(2'd2, 8'd3);
    for (int i = 0; i < 18; i++) wr(2'd0, 8'(i * 7 + 1));
    rd(2'd3, "R2 overflow flag");
    chk(cpu_rdata[2] == 1, "R2 overflow set", int'(cpu_rdata[2]), 1);
    wr(2'd3, 8'h04);
    rd(2'd3, "R2 overflow cleared");
    wait_idle(); repeat (2) @(negedge clk);
    drain_rx(17);
    rd(2'd0, "R7 empty read zero");
    chk(cpu_rdata == 8'h00, "R7 empty read value", int'(cpu_rdata), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule